// File: doc/BRIEF.md
# Multi-Lane Serial Flash Target Front-End

This block is the serial edge of a flash-style target device. It watches chip select and the serial clock, collects an 8-bit instruction and a 24-bit address, and then either gathers write bytes or launches read bytes. Depending on the instruction, data moves on one, two or four lanes. The serial clock is oversampled by the core clock. All pins are assumed to be already synchronised to that clock, and the serial clock must stay at each level for at least two core cycles.

On the core side, a one-cycle strobe carries the instruction and the address. A second strobe carries each completed write byte. A third strobe tells the core that the read byte on `rd_data` has been taken, so the next byte can be placed there. The fourth pin doubles as a pause input. Outside four-lane commands, pulling it low freezes the transfer in place. Entry into and exit from the pause wait for the serial clock to be low.

Top module: `flash_spi_frontend`

## Requirements
- R1: Bits are taken from the pins on rising serial-clock edges while `cs_n` is low. The instruction arrives MSB first on `io_in[0]`, followed by the address MSB first. One cycle after the last address bit is sampled, `cmd_valid` pulses for a single core cycle, with `cmd_op` and `cmd_addr` holding the received values.
- R2: The same transfers work whether the serial clock idles low or idles high while `cs_n` is high. An idle-high clock causes a falling edge before the first rising edge, and that falling edge has no effect.
- R3: Read bits change only after falling serial-clock edges. The first bit appears after the falling edge that follows the last non-data clock. Instruction 0x03 has no dummy clocks and 0x0B has 8 dummy clocks. Both drive bytes MSB first on `io_out[1]`. `rd_next` pulses each time a new byte is loaded from `rd_data`.
- R4: Instruction 0x3B takes the address on one lane, then 8 dummy clocks, then read data on two lanes. Instruction 0xBB takes the address on two lanes, then 4 dummy clocks, then two-lane data. In both, `io[1]` carries the higher bit of each pair.
- R5: Instruction 0x6B takes the address on one lane, then 8 dummy clocks, then four-lane reads. Instruction 0xEB takes the address on four lanes, then 6 dummy clocks, then four-lane reads. Instructions 0x32 and 0x34 take the address on one lane and then write data on four lanes. In all four, `io[3]` carries the highest bit of each nibble.
- R6: `io_oe` is zero except during the data phase of a read instruction. When it is active, it covers `4'b0010` for one lane, `4'b0011` for two lanes, and `4'b1111` for four lanes.
- R7: The pause starts when `io_in[3]` is low and the serial clock is low. If the pin falls while the clock is high, the next falling edge is still acted on, and the pause starts after it.
- R8: The pause ends when `io_in[3]` is high and the serial clock is low. If the pin rises while the clock is high, the transfer stays paused, and the next falling edge is swallowed.
- R9: While paused, `io_oe` is zero, and serial-clock edges and data pins are ignored. The current output bit, the bit position, the address and the instruction are kept, and the transfer resumes exactly where it stopped.
- R10: Once a two-lane or four-lane... once a four-lane instruction (0x6B, 0xEB, 0x32, 0x34) has been decoded, `io_in[3]` is data only and never pauses the transfer.
- R11: `cs_n` high, including during a pause, ends the pause and returns the sequencer to waiting for a new instruction.
- R12: An instruction not listed above causes no strobe and no output enable until `cs_n` rises.
- R13: Instruction 0x02 takes the address on one lane and then write bytes MSB first on `io_in[0]`. `wr_valid` pulses once per completed byte, with that byte on `wr_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| io_in | input | 4 | Pin input values; bit 3 is also the pause input |
| io_out | output | 4 | Pin output values |
| io_oe | output | 4 | Per-pin output enable |
| cmd_valid | output | 1 | Instruction and address strobe |
| cmd_op | output | 8 | Received instruction byte |
| cmd_addr | output | ADDR_W | Received address |
| wr_valid | output | 1 | Write byte strobe |
| wr_byte | output | 8 | Received write byte |
| rd_next | output | 1 | Read byte taken; present the next one |
| rd_data | input | 8 | Read byte from the core |

## Verification
The main case where two functions meet is a pause request and a serial clock edge falling close together. A pause requested while the clock is high has to let the next falling edge through. A release while the clock is high has to swallow that edge. The bench provokes both orderings in the middle of a byte, once in a read and once in a write. It judges the result from the visible output bit and the output enables right after the pause, and from the write bytes that come out. A further case raises chip select while a pause is active.

// File: rtl/flash_fe_pkg.sv
// Shared types for the serial flash front-end: transfer phases and the
// per-instruction lane/dummy profile. Assumes lane counts of 1, 2 or 4.
package flash_fe_pkg;

    typedef enum logic [2:0] {
        PH_OPC,   // collecting the instruction byte
        PH_ADR,   // collecting the address
        PH_DMY,   // dummy clocks
        PH_DAT,   // data transfer
        PH_IGN    // unknown instruction, wait for deselect
    } phase_e;

    typedef struct packed {
        logic       known;
        logic       rd;
        logic [2:0] alanes;
        logic [2:0] dlanes;
        logic [3:0] dummy;
    } cmd_t;

    // Map an instruction byte to its lane and dummy profile.
    function automatic cmd_t decode_op(input logic [7:0] op);
        cmd_t d;
        case (op)
            8'h03:         d = '{1'b1, 1'b1, 3'd1, 3'd1, 4'd0};
            8'h0B:         d = '{1'b1, 1'b1, 3'd1, 3'd1, 4'd8};
            8'h3B:         d = '{1'b1, 1'b1, 3'd1, 3'd2, 4'd8};
            8'hBB:         d = '{1'b1, 1'b1, 3'd2, 3'd2, 4'd4};
            8'h6B:         d = '{1'b1, 1'b1, 3'd1, 3'd4, 4'd8};
            8'hEB:         d = '{1'b1, 1'b1, 3'd4, 3'd4, 4'd6};
            8'h02:         d = '{1'b1, 1'b0, 3'd1, 3'd1, 4'd0};
            8'h32, 8'h34:  d = '{1'b1, 1'b0, 3'd1, 3'd4, 4'd0};
            default:       d = '{1'b0, 1'b0, 3'd1, 3'd1, 4'd0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fe_hold_gate.sv
// Serial clock edge detection and pause qualification.
// Assumes sclk, cs_n and hold_n are already synchronous to clk.
// The pause state only moves while the sampled serial clock is low. When
// paused, no serial edge is reported.
module fe_hold_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic hold_n,
    input  logic quad,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic held
);
    logic sclk_q;
    logic held_q;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Follow the pause pin only while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n || quad) held_q <= 1'b0;
        else if (!sclk)             held_q <= ~hold_n;
    end

    assign sclk_rise = sclk & ~sclk_q & ~cs_n & ~held_q;
    assign sclk_fall = ~sclk & sclk_q & ~cs_n & ~held_q;
    assign held      = held_q;

    // R7: a pause never begins while the serial clock is high
    a_r7_no_entry_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_q && sclk) |=> !held_q);

    // R8: a pause never ends while the serial clock is high
    a_r8_no_exit_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && sclk && !cs_n && !quad) |=> held_q);

endmodule

// File: rtl/fe_cmd_seq.sv
// Command sequencer: instruction, address, dummy and write-data collection.
// Acts only on qualified rising serial edges. Deselect restarts it.
module fe_cmd_seq
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rise,
    input  logic [3:0]        io_in,
    output logic              rd_phase,
    output logic [2:0]        dlanes,
    output logic              quad,
    output logic              cmd_valid,
    output logic [7:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_valid,
    output logic [7:0]        wr_byte
);
    localparam int CW = $clog2(ADDR_W + 1);

    phase_e            phase_q;
    logic [CW-1:0]     cnt_q;
    logic [7:0]        op_q;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        byte_q;
    logic              cmd_valid_q;
    logic              wr_valid_q;
    logic [7:0]        wr_byte_q;

    logic [7:0]        op_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic [7:0]        byte_nx;
    logic [CW-1:0]     adr_clks;
    logic [CW-1:0]     byte_clks;
    logic [CW-1:0]     cnt_inc;
    cmd_t              dec;

    // Shift the sampled lanes into the address and data registers.
    always_comb begin
        op_nx   = {op_q[6:0], io_in[0]};
        dec     = decode_op(op_nx);
        cnt_inc = cnt_q + CW'(1);
        case (cmd_q.alanes)
            3'd4: begin addr_nx = {addr_q[ADDR_W-5:0], io_in};      adr_clks = CW'(ADDR_W / 4); end
            3'd2: begin addr_nx = {addr_q[ADDR_W-3:0], io_in[1:0]}; adr_clks = CW'(ADDR_W / 2); end
            default: begin addr_nx = {addr_q[ADDR_W-2:0], io_in[0]}; adr_clks = CW'(ADDR_W); end
        endcase
        case (cmd_q.dlanes)
            3'd4: begin byte_nx = {byte_q[3:0], io_in};      byte_clks = CW'(2); end
            3'd2: begin byte_nx = {byte_q[5:0], io_in[1:0]}; byte_clks = CW'(4); end
            default: begin byte_nx = {byte_q[6:0], io_in[0]}; byte_clks = CW'(8); end
        endcase
    end

    // Advance through the phases on each qualified rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            phase_q     <= PH_OPC;
            cnt_q       <= '0;
            cmd_q       <= '0;
            cmd_valid_q <= 1'b0;
            wr_valid_q  <= 1'b0;
        end else begin
            cmd_valid_q <= 1'b0;
            wr_valid_q  <= 1'b0;
            if (rise) begin
                case (phase_q)
                    PH_OPC: begin
                        op_q <= op_nx;
                        if (cnt_inc == CW'(8)) begin
                            cnt_q   <= '0;
                            cmd_q   <= dec;
                            phase_q <= dec.known ? PH_ADR : PH_IGN;
                        end else cnt_q <= cnt_inc;
                    end
                    PH_ADR: begin
                        addr_q <= addr_nx;
                        if (cnt_inc == adr_clks) begin
                            cnt_q       <= '0;
                            cmd_valid_q <= 1'b1;
                            phase_q     <= (cmd_q.dummy != 4'd0) ? PH_DMY : PH_DAT;
                        end else cnt_q <= cnt_inc;
                    end
                    PH_DMY: begin
                        if (cnt_inc == CW'(cmd_q.dummy)) begin
                            cnt_q   <= '0;
                            phase_q <= PH_DAT;
                        end else cnt_q <= cnt_inc;
                    end
                    PH_DAT: begin
                        if (!cmd_q.rd) begin
                            byte_q <= byte_nx;
                            if (cnt_inc == byte_clks) begin
                                cnt_q      <= '0;
                                wr_valid_q <= 1'b1;
                                wr_byte_q  <= byte_nx;
                            end else cnt_q <= cnt_inc;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_phase  = (phase_q == PH_DAT) && cmd_q.rd;
    assign dlanes    = cmd_q.dlanes;
    assign quad      = (cmd_q.dlanes == 3'd4);
    assign cmd_valid = cmd_valid_q;
    assign cmd_op    = op_q;
    assign cmd_addr  = addr_q;
    assign wr_valid  = wr_valid_q;
    assign wr_byte   = wr_byte_q;

    // R11: a deselect always brings the sequencer back to the instruction phase
    a_r11_deselect_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase_q == PH_OPC && cnt_q == '0));

    // R1: the command strobe lasts exactly one core cycle
    a_r1_cmd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_q |=> !cmd_valid_q);

    // R12: an unknown instruction produces no strobes
    a_r12_unknown_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IGN) |-> (!cmd_valid_q && !wr_valid_q));

endmodule

// File: rtl/fe_tx_shift.sv
// Read-data launcher. It loads a byte from the core and presents it on the
// lanes, changing only on qualified falling serial edges. Assumes the core
// updates rd_data within a few core cycles of rd_next.
module fe_tx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       fall,
    input  logic       rd_phase,
    input  logic [2:0] dlanes,
    input  logic       held,
    input  logic [7:0] rd_data,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    output logic       rd_next
);
    logic [7:0] sh_q;
    logic [2:0] left_q;
    logic       on_q;
    logic       rd_next_q;
    logic [3:0] mask;
    logic [2:0] per_byte;

    // Lane mask and the number of clocks left after loading a byte.
    always_comb begin
        case (dlanes)
            3'd4:    begin mask = 4'b1111; per_byte = 3'd1; io_out = sh_q[7:4]; end
            3'd2:    begin mask = 4'b0011; per_byte = 3'd3; io_out = {2'b00, sh_q[7:6]}; end
            default: begin mask = 4'b0010; per_byte = 3'd7; io_out = {2'b00, sh_q[7], 1'b0}; end
        endcase
    end

    // Load or shift the outgoing byte on each qualified falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            sh_q      <= '0;
            left_q    <= '0;
            on_q      <= 1'b0;
            rd_next_q <= 1'b0;
        end else begin
            rd_next_q <= 1'b0;
            if (fall && rd_phase) begin
                if (left_q == 3'd0) begin
                    sh_q      <= rd_data;
                    left_q    <= per_byte;
                    rd_next_q <= 1'b1;
                    on_q      <= 1'b1;
                end else begin
                    sh_q   <= sh_q << dlanes;
                    left_q <= left_q - 3'd1;
                end
            end
        end
    end

    assign io_oe   = (on_q && !held) ? mask : 4'b0000;
    assign rd_next = rd_next_q;

    // R3: the outgoing bits only move after a falling serial edge
    a_r3_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !cs_n) |=> $stable(sh_q));

    // R9: a pause freezes the outgoing bits
    a_r9_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_n) |=> $stable(sh_q));

    // R6: pins are driven only in the data phase of a read
    a_r6_oe_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != 4'b0000) |-> rd_phase);

endmodule

// File: rtl/flash_spi_frontend.sv
// Top of the serial flash front-end. It wires the edge/pause gate, the
// command sequencer and the read launcher. Pin 3 serves as the pause input
// whenever no four-lane instruction is active.
module flash_spi_frontend #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic              cmd_valid,
    output logic [7:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_valid,
    output logic [7:0]        wr_byte,
    output logic              rd_next,
    input  logic [7:0]        rd_data
);
    logic       rise, fall, held;
    logic       quad, rd_phase;
    logic [2:0] dlanes;

    fe_hold_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .hold_n    (io_in[3]),
        .quad      (quad),
        .sclk_rise (rise),
        .sclk_fall (fall),
        .held      (held)
    );

    fe_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rise      (rise),
        .io_in     (io_in),
        .rd_phase  (rd_phase),
        .dlanes    (dlanes),
        .quad      (quad),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .wr_valid  (wr_valid),
        .wr_byte   (wr_byte)
    );

    fe_tx_shift u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .fall     (fall),
        .rd_phase (rd_phase),
        .dlanes   (dlanes),
        .held     (held),
        .rd_data  (rd_data),
        .io_out   (io_out),
        .io_oe    (io_oe),
        .rd_next  (rd_next)
    );

    // R10: a decoded four-lane instruction leaves no pause active
    a_r10_quad_ignores_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (quad && $past(quad)) |-> !held);

endmodule

// File: tb/tb_flash_spi_frontend.sv
// Behavioural reference bench: host-side serial tasks, queues of expected
// strobes and a per-clock check of the output enables.
module tb_flash_spi_frontend;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n;
    logic        sclk;
    logic [3:0]  io_in;
    logic [3:0]  io_out, io_oe;
    logic        cmd_valid, wr_valid, rd_next;
    logic [7:0]  cmd_op, wr_byte;
    logic [23:0] cmd_addr;
    logic [7:0]  rd_data;

    int vec = 0;
    int errs = 0;
    int rd_idx = 0;
    bit done = 0;
    bit rd_window = 0;
    logic [7:0]  q_op[$];
    logic [23:0] q_addr[$];
    logic [7:0]  q_wr[$];

    always #2 clk = ~clk;

    flash_spi_frontend dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .rd_next(rd_next), .rd_data(rd_data)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'hA5 ^ 8'(k * 59);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Core-side model: record strobes, serve read bytes, and watch the enables.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (cmd_valid) begin q_op.push_back(cmd_op); q_addr.push_back(cmd_addr); end
            if (wr_valid) q_wr.push_back(wr_byte);
            if (rd_next) begin rd_idx++; rd_data = pat(rd_idx); end
            if (!rd_window) check("R6 enables outside read data", {28'd0, io_oe}, 32'd0);
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input bit mode3);
        sclk = mode3; io_in = 4'hF; rd_idx = 0; rd_data = pat(0);
        wt(2); cs_n = 1'b0; wt(4);
    endtask

    task automatic finish(input bit mode3);
        if (!mode3 && sclk) begin sclk = 1'b0; wt(4); end
        cs_n = 1'b1; io_in = 4'hF; wt(6);
        rd_window = 0; wt(2);
    endtask

    task automatic bit_in(input logic [3:0] v);
        if (sclk) begin sclk = 1'b0; wt(4); end
        io_in = v; wt(4);
        sclk = 1'b1; wt(4);
    endtask

    task automatic send(input int lanes, input logic [31:0] val, input int nbits);
        for (int c = 0; c < nbits / lanes; c++) begin
            logic [31:0] ch;
            ch = val >> (nbits - lanes * (c + 1));
            case (lanes)
                4: bit_in(ch[3:0]);
                2: bit_in({2'b11, ch[1:0]});
                default: bit_in({3'b110, ch[0]});
            endcase
        end
    endtask

    task automatic dummies(input int n);
        for (int i = 0; i < n; i++) bit_in(4'hF);
    endtask

    // One read clock: fall, check the expected lanes, rise.
    task automatic rd_clk(input string req, input int lanes, input logic [7:0] b, input int j);
        logic [3:0] m, e;
        logic [7:0] s;
        s = b >> (8 - lanes * (j + 1));
        case (lanes)
            4: begin m = 4'hF; e = s[3:0]; end
            2: begin m = 4'h3; e = {2'b00, s[1:0]}; end
            default: begin m = 4'h2; e = {2'b00, s[0], 1'b0}; end
        endcase
        sclk = 1'b0; wt(4);
        check(req, {24'd0, io_oe, io_out & io_oe}, {24'd0, m, e});
        sclk = 1'b1; wt(4);
    endtask

    task automatic rd_bytes(input string req, input int lanes, input int n, input logic [3:0] idle);
        io_in = idle;
        for (int k = 0; k < n; k++)
            for (int j = 0; j < 8 / lanes; j++) rd_clk(req, lanes, pat(k), j);
    endtask

    task automatic expect_cmd(input string req, input logic [7:0] op, input logic [23:0] a);
        check({req, " command count"}, q_op.size(), 1);
        if (q_op.size() > 0) begin
            check({req, " opcode"}, {24'd0, q_op[0]}, {24'd0, op});
            check({req, " address"}, {8'd0, q_addr[0]}, {8'd0, a});
        end
        q_op.delete(); q_addr.delete();
    endtask

    task automatic expect_wr(input string req, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input int n);
        logic [7:0] exp[3];
        exp = '{b0, b1, b2};
        check({req, " write count"}, q_wr.size(), n);
        for (int i = 0; i < n && i < q_wr.size(); i++)
            check({req, " write byte"}, {24'd0, q_wr[i]}, {24'd0, exp[i]});
        q_wr.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++; vec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; io_in = 4'hF; rd_data = 8'h00;
        wt(5);
        rst_n = 1'b1; wt(2);
        check("R6 reset enables", {28'd0, io_oe}, 0);
        check("R1 reset strobe", {31'd0, cmd_valid}, 0);
        check("R13 reset write strobe", {31'd0, wr_valid}, 0);

        // R12: unknown instruction then many clocks: no strobes, no drive
        start(0); send(1, 8'h9F, 8); send(1, 32'hFFFF_FFFF, 32); finish(0);
        check("R12 no command", q_op.size(), 0);
        check("R12 no write", q_wr.size(), 0);
        q_op.delete(); q_wr.delete();

        // R1 R3: 0x03 single-lane read, idle-low clock
        start(0); send(1, 8'h03, 8); send(1, 24'h123456, 24);
        rd_window = 1; rd_bytes("R3 read 03h", 1, 3, 4'hF); finish(0);
        expect_cmd("R1 03h", 8'h03, 24'h123456);

        // R2 R3: 0x0B with dummies, idle-high clock
        start(1); send(1, 8'h0B, 8); send(1, 24'hABCDEF, 24); dummies(8);
        rd_window = 1; rd_bytes("R2 read 0Bh idle-high", 1, 2, 4'hF); finish(1);
        expect_cmd("R2 0Bh", 8'h0B, 24'hABCDEF);

        // R4: 0x3B dual output
        start(0); send(1, 8'h3B, 8); send(1, 24'h00F00D, 24); dummies(8);
        rd_window = 1; rd_bytes("R4 read 3Bh", 2, 2, 4'hF); finish(0);
        expect_cmd("R4 3Bh", 8'h3B, 24'h00F00D);

        // R4: 0xBB dual address and data
        start(1); send(1, 8'hBB, 8); send(2, 24'h5A3C96, 24); dummies(4);
        rd_window = 1; rd_bytes("R4 read BBh", 2, 3, 4'hF); finish(1);
        expect_cmd("R4 BBh", 8'hBB, 24'h5A3C96);

        // R5 R10: 0x6B quad output with pin 3 held low throughout the data
        start(0); send(1, 8'h6B, 8); send(1, 24'h010203, 24); dummies(8);
        rd_window = 1; rd_bytes("R10 read 6Bh pin3 low", 4, 3, 4'h0); finish(0);
        expect_cmd("R5 6Bh", 8'h6B, 24'h010203);

        // R5: 0xEB quad address and data, idle-high clock
        start(1); send(1, 8'hEB, 8); send(4, 24'hC0FFEE, 24); dummies(6);
        rd_window = 1; rd_bytes("R5 read EBh", 4, 3, 4'hF); finish(1);
        expect_cmd("R5 EBh", 8'hEB, 24'hC0FFEE);

        // R13: single-lane write
        start(0); send(1, 8'h02, 8); send(1, 24'h000200, 24);
        send(1, 8'h81, 8); send(1, 8'h3E, 8); send(1, 8'hF0, 8); finish(0);
        expect_cmd("R13 02h", 8'h02, 24'h000200);
        expect_wr("R13", 8'h81, 8'h3E, 8'hF0, 3);

        // R5 R10: quad write with pin 3 low in several nibbles
        start(0); send(1, 8'h32, 8); send(1, 24'h000400, 24);
        send(4, 8'h0F, 8); send(4, 8'h00, 8); send(4, 8'h7E, 8); finish(0);
        expect_cmd("R5 32h", 8'h32, 24'h000400);
        expect_wr("R10 32h pin3 low", 8'h0F, 8'h00, 8'h7E, 3);
        start(1); send(1, 8'h34, 8); send(1, 24'h000404, 24);
        send(4, 8'h12, 8); send(4, 8'hED, 8); finish(1);
        expect_cmd("R5 34h", 8'h34, 24'h000404);
        expect_wr("R5 34h", 8'h12, 8'hED, 8'h00, 2);

        // R7 R8 R9: pause in a read, entry with the clock low, exit with it high
        start(0); send(1, 8'h03, 8); send(1, 24'h000010, 24);
        rd_window = 1; io_in = 4'hF;
        for (int j = 0; j < 3; j++) rd_clk("R9 before pause", 1, pat(0), j);
        sclk = 1'b0; wt(4);
        check("R9 bit 3 shown", {28'd0, io_oe, io_out[1]}, {28'd0, 4'b0010, pat(0)[4]});
        io_in[3] = 1'b0; wt(3);
        check("R7 entry with clock low", {28'd0, io_oe}, 0);
        sclk = 1'b1; wt(4); sclk = 1'b0; wt(4); sclk = 1'b1; wt(4); sclk = 1'b0; wt(4);
        check("R9 edges ignored while paused", {28'd0, io_oe}, 0);
        sclk = 1'b1; wt(4); io_in[3] = 1'b1; wt(4);
        check("R8 still paused with clock high", {28'd0, io_oe}, 0);
        sclk = 1'b0; wt(4);
        check("R8 resume keeps bit 3", {28'd0, io_oe, io_out[1]}, {28'd0, 4'b0010, pat(0)[4]});
        sclk = 1'b1; wt(4);
        for (int j = 4; j < 8; j++) rd_clk("R9 after pause", 1, pat(0), j);
        for (int j = 0; j < 8; j++) rd_clk("R9 next byte", 1, pat(1), j);
        finish(0);
        expect_cmd("R9 03h", 8'h03, 24'h000010);

        // R7 R8 R9: pause in a write, entry with the clock high, exit with it low
        start(0); send(1, 8'h02, 8); send(1, 24'h000300, 24);
        send(1, 8'hC, 4);
        io_in[3] = 1'b0; wt(4);
        sclk = 1'b0; wt(4);
        io_in[0] = 1'b1; wt(2); sclk = 1'b1; wt(4); sclk = 1'b0; wt(4);
        io_in[3] = 1'b1; wt(4);
        send(1, 8'h3, 4); send(1, 8'h5A, 8); finish(0);
        expect_cmd("R7 02h", 8'h02, 24'h000300);
        expect_wr("R8 pause in write", 8'hC3, 8'h5A, 8'h00, 2);

        // R11: deselect during a pause, then a fresh command
        start(0); send(1, 8'h03, 8); send(1, 5'h1F, 5);
        sclk = 1'b0; io_in[3] = 1'b0; wt(4);
        cs_n = 1'b1; wt(4); io_in[3] = 1'b1; wt(4);
        check("R11 no command from aborted frame", q_op.size(), 0);
        start(0); send(1, 8'h0B, 8); send(1, 24'h765432, 24); dummies(8);
        rd_window = 1; rd_bytes("R11 read after abort", 1, 1, 4'hF); finish(0);
        expect_cmd("R11 0Bh", 8'h0B, 24'h765432);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
        $finish;
    end
endmodule